// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is an 8-bit up-counting timer that produces a pulse-width-modulated waveform. It has two compare values. The period value N sets the length of one PWM cycle, and the duty value M sets how long the output stays active within that cycle. The counter is compared against only one of the two values at a time. After enable it first looks for the period value. A period match clears the counter, raises a one-clock interrupt pulse, drives the output active and moves the comparison to the duty value. A duty match drives the output back to its inactive level and moves the comparison back to the period value.

Software configures the block through a small write port with three registers: control, period and duty. The control register holds a run bit, a 3-bit prescaler select, a 2-bit mode field, the idle output level and an output enable. The duty value may be rewritten while the timer counts. A period write is dropped while the run bit is set. A valid setting satisfies 00h <= M < N <= FFh.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the output is low and the interrupt is low. The period register holds FFh, the duty register holds 00h and the control register holds 00h.
- R2: A write with address 0 loads the control register: bit 7 run, bits 6:4 prescaler select k, bits 3:2 mode, bit 1 idle level, bit 0 output enable. Address 1 loads the period N, address 2 loads the duty M, and a write to address 3 changes nothing.
- R3: The counter runs only while run is 1 and mode is 2'b10. It starts at 0 and first compares against N. On a count tick with the counter equal to N, the counter clears, the interrupt pulses high for one clock and the output turns active. With k=0 the interrupt is seen N+1 clocks after the enabling write, and the output holds the idle level until then.
- R4: After a period match the counter compares against M. On a tick with the counter equal to M, the output turns inactive and the comparison returns to N. Each cycle therefore lasts N+1 ticks, of which M+1 are active.
- R5: The count tick fires once every 2^k clocks, where k is the prescaler select (0 to 7). All PWM timing scales by that factor.
- R6: A write to the period register while run is 1 is ignored. The same write while run is 0 is accepted.
- R7: A duty write while running is accepted and sets the active length of the following cycles.
- R8: The idle-level bit sets the inactive output level, and the active level is its inverse. With output enable 0 the output holds the idle level, while interrupts continue at each period match.
- R9: Clearing run resets the counter to 0, resets the compare target to the period value and makes the output inactive one clock after the write. While stopped no interrupt occurs. A restart times its first match as in R3.
- R10: With run 1 and a mode other than 2'b10 the counter does not advance and no interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 period, 2 duty |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 1 | PWM waveform |
| irq_o | output | 1 | One-clock pulse at each period match |

## Verification
The checks that no interrupt follows another in the next clock, and that the output is active in the interrupt cycle, assume a valid setting with N of at least 1 and M below N. The stimulus always configures the block with run at 0 and mode 2'b10 before it sets run, and every period and duty pair it uses satisfies M < N. The lock on the period register is exercised by writes made while running. The duty value is changed only during a period whose outcome is not checked.

// File: rtl/pwm_timer8_pkg.sv
`timescale 1ns/1ps
package pwm_timer8_pkg;

  localparam int CKS_W  = 3;
  localparam int MODE_W = 2;
  localparam int ADDR_W = 2;

  localparam logic [MODE_W-1:0] MODE_PWM = 2'b10;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY   = 2'd2;

  typedef enum logic {
    TGT_PERIOD = 1'b0,
    TGT_DUTY   = 1'b1
  } cmp_tgt_e;

  typedef struct packed {
    logic              run;
    logic [CKS_W-1:0]  cks;
    logic [MODE_W-1:0] mode;
    logic              idle_lvl;
    logic              out_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_timer8_regs.sv
`timescale 1ns/1ps
module pwm_timer8_regs
  import pwm_timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  duty_o
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic             ctrl_ld, period_ld, duty_ld;

  always_comb begin
    ctrl_ld   = 1'b0;
    period_ld = 1'b0;
    duty_ld   = 1'b0;
    if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_CTRL:   ctrl_ld   = 1'b1;
        ADDR_PERIOD: period_ld = !ctrl_q.run;
        ADDR_DUTY:   duty_ld   = 1'b1;
        default:     ;
      endcase
    end
    ctrl_d   = ctrl_t'(wr_data_i[CTRL_W-1:0]);
    period_d = wr_data_i;
    duty_d   = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_ld) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '1;
    end else if (period_ld) begin
      period_q <= period_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
    end else if (duty_ld) begin
      duty_q <= duty_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign period_o = period_q;
  assign duty_o   = duty_q;

  logic run_q;
  assign run_q = ctrl_q.run;

  // R6: the period value never moves across an edge taken with run set
  a_r6_period_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_q) |-> $stable(period_q))
    else $error("period register changed while running");

endmodule

// File: rtl/pwm_timer8_presc.sv
`timescale 1ns/1ps
module pwm_timer8_presc
  import pwm_timer8_pkg::*;
#(
  parameter int SEL_W = CKS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int NTAPS = 1 << SEL_W;
  localparam int DIV_W = NTAPS - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [NTAPS-1:0] taps;

  always_comb begin
    if (en_i) begin
      div_d = div_q + 1'b1;
    end else begin
      div_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  for (genvar gi = 0; gi < NTAPS; gi++) begin : g_tap
    if (gi == 0) begin : g_every
      assign taps[gi] = 1'b1;
    end else begin : g_div
      assign taps[gi] = &div_q[gi-1:0];
    end
  end

  assign tick_o = en_i & taps[sel_i];

  // R5: a divided tick is never followed by another one in the next clock
  a_r5_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i != '0) |=> (!tick_o || sel_i == '0))
    else $error("prescaler ticks too close together");

endmodule

// File: rtl/pwm_timer8_core.sv
`timescale 1ns/1ps
module pwm_timer8_core
  import pwm_timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             active_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cmp_tgt_e         tgt_q, tgt_d;
  logic             act_q, act_d;
  logic             irq_q, irq_d;
  logic             state_ld;
  logic             hit_period, hit_duty;

  assign hit_period = (tgt_q == TGT_PERIOD) && (cnt_q == period_i);
  assign hit_duty   = (tgt_q == TGT_DUTY) && (cnt_q == duty_i);
  assign state_ld   = !en_i || tick_i;

  always_comb begin
    cnt_d = cnt_q;
    tgt_d = tgt_q;
    act_d = act_q;
    irq_d = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
      tgt_d = TGT_PERIOD;
      act_d = 1'b0;
    end else if (tick_i) begin
      if (hit_period) begin
        cnt_d = '0;
        tgt_d = TGT_DUTY;
        act_d = 1'b1;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (hit_duty) begin
          tgt_d = TGT_PERIOD;
          act_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tgt_q <= TGT_PERIOD;
      act_q <= 1'b0;
    end else if (state_ld) begin
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign active_o = act_q;
  assign irq_o    = irq_q;

  // R3: the interrupt cycle shows a cleared counter, active output, duty target
  a_r3_clear_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cnt_q == '0 && act_q && tgt_q == TGT_DUTY))
    else $error("period match state wrong");

  // R4: while enabled, the output only drops on a duty match
  a_r4_release_at_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(act_q) && $past(en_i)) |-> ($past(cnt_q) == $past(duty_i) && tgt_q == TGT_PERIOD))
    else $error("output released away from duty match");

  // R9: a disabled counter is parked at zero, inactive, on the period target
  a_r9_stop_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && !act_q && tgt_q == TGT_PERIOD))
    else $error("stopped state not parked");

endmodule

// File: rtl/pwm_timer8_out.sv
`timescale 1ns/1ps
module pwm_timer8_out (
  input  logic active_i,
  input  logic idle_lvl_i,
  input  logic out_en_i,
  output logic pwm_o
);

  always_comb begin
    pwm_o = idle_lvl_i ^ (out_en_i & active_i);
  end

endmodule

// File: rtl/pwm_timer8.sv
`timescale 1ns/1ps
module pwm_timer8
  import pwm_timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              pwm_o,
  output logic              irq_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  ctrl_t            ctrl;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] duty;
  logic             count_en;
  logic             tick;
  logic             active;

  pwm_timer8_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .period_o  (period),
    .duty_o    (duty)
  );

  assign count_en = ctrl.run && (ctrl.mode == MODE_PWM);

  pwm_timer8_presc #(.SEL_W(CKS_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .en_i   (count_en),
    .sel_i  (ctrl.cks),
    .tick_o (tick)
  );

  pwm_timer8_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .en_i     (count_en),
    .tick_i   (tick),
    .period_i (period),
    .duty_i   (duty),
    .active_o (active),
    .irq_o    (irq_o)
  );

  pwm_timer8_out u_out (
    .active_i   (active),
    .idle_lvl_i (ctrl.idle_lvl),
    .out_en_i   (ctrl.out_en),
    .pwm_o      (pwm_o)
  );

  // R3: the interrupt is a single-clock pulse (valid settings have N >= 1)
  a_r3_irq_single: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    irq_o |=> !irq_o)
    else $error("interrupt wider than one clock");

  // R8: with the output enabled, the pin is at the active level on a period match
  a_r8_active_level: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (irq_o && ctrl.out_en) |-> (pwm_o != ctrl.idle_lvl))
    else $error("pin not active at period match");

  // R10: outside PWM mode no interrupt is raised
  a_r10_mode_gate: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (ctrl.mode != MODE_PWM && $past(ctrl.mode != MODE_PWM)) |-> !irq_o)
    else $error("interrupt outside PWM mode");

endmodule

// File: tb/pwm_timer8_test.sv
`timescale 1ns/1ps
module pwm_timer8_test;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       pwm;
  logic       irq;

  int n_checks = 0;
  int n_errors = 0;

  pwm_timer8 uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .pwm_o     (pwm),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // table entry: {N[7:0], M[7:0], k[2:0], idle, oe}
  localparam int NVEC = 5;
  localparam logic [20:0] VEC [NVEC] = '{
    {8'd9,   8'd3,   3'd0, 1'b0, 1'b1},
    {8'd4,   8'd0,   3'd0, 1'b1, 1'b1},
    {8'd255, 8'd254, 3'd0, 1'b0, 1'b1},
    {8'd7,   8'd2,   3'd2, 1'b0, 1'b1},
    {8'd1,   8'd0,   3'd3, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic [7:0] ctrl_byte(input logic run, input logic [2:0] k,
                                           input logic [1:0] mode, input logic idle,
                                           input logic oe);
    return {run, k, mode, idle, oe};
  endfunction

  // number of negedges until irq is seen; -1 if not within limit
  task automatic wait_irq(input int limit, output int cyc);
    cyc = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (irq) begin
        cyc = i;
        break;
      end
    end
  endtask

  task automatic measure(input logic idle, output int act_len, output int per_len,
                         output int irq_after, output int lvl_active);
    int c;
    wait_irq(5000, c);
    lvl_active = (pwm == ~idle) ? 1 : 0;
    act_len   = -1;
    per_len   = -1;
    irq_after = -1;
    if (c < 0) return;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk);
      if (i == 1) irq_after = int'(irq);
      if (act_len < 0 && pwm == idle) act_len = i;
      if (irq) begin
        per_len = i;
        break;
      end
    end
  endtask

  task automatic setup(input logic [7:0] n, input logic [7:0] m, input logic [2:0] k,
                       input logic idle, input logic oe);
    wr(2'd0, ctrl_byte(1'b0, k, 2'b10, idle, oe));
    wr(2'd1, n);
    wr(2'd2, m);
    wr(2'd0, ctrl_byte(1'b1, k, 2'b10, idle, oe));
  endtask

  initial begin
    #600000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int a_len, p_len, i_aft, lvl, c, bad;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 pwm after reset", int'(pwm), 0);
    chk("R1 irq after reset", int'(irq), 0);

    // R2 R4 R5 R8: table of settings
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] n, m;
      logic [2:0] k;
      logic       idle, oe;
      {n, m, k, idle, oe} = VEC[v];
      setup(n, m, k, idle, oe);
      measure(idle, a_len, p_len, i_aft, lvl);
      chk($sformatf("R4 R5 active length vec%0d", v), a_len, (int'(m) + 1) << k);
      chk($sformatf("R4 R5 period length vec%0d", v), p_len, (int'(n) + 1) << k);
      chk($sformatf("R3 irq one clock vec%0d", v), i_aft, 0);
      chk($sformatf("R8 active level vec%0d", v), lvl, 1);
      wr(2'd0, ctrl_byte(1'b0, k, 2'b10, idle, oe));
    end

    // R3: first match timing from enable, idle before it
    wr(2'd0, ctrl_byte(1'b0, 3'd0, 2'b10, 1'b0, 1'b1));
    wr(2'd1, 8'd5);
    wr(2'd2, 8'd2);
    wr(2'd0, ctrl_byte(1'b1, 3'd0, 2'b10, 1'b0, 1'b1));
    bad = 0;
    c = -1;
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      if (irq) begin
        c = i;
        break;
      end
      if (pwm != 1'b0) bad++;
    end
    chk("R3 first irq cycle", c, 6);
    chk("R3 idle before first match", bad, 0);

    // R6 R2: period write while running ignored, address 3 ignored
    wr(2'd0, ctrl_byte(1'b0, 3'd0, 2'b10, 1'b0, 1'b1));
    setup(8'd9, 8'd3, 3'd0, 1'b0, 1'b1);
    wr(2'd1, 8'd20);
    wr(2'd3, 8'h55);
    measure(1'b0, a_len, p_len, i_aft, lvl);
    chk("R6 period kept while running", p_len, 10);
    chk("R2 address 3 leaves duty", a_len, 4);
    wr(2'd0, ctrl_byte(1'b0, 3'd0, 2'b10, 1'b0, 1'b1));
    wr(2'd1, 8'd20);
    wr(2'd0, ctrl_byte(1'b1, 3'd0, 2'b10, 1'b0, 1'b1));
    measure(1'b0, a_len, p_len, i_aft, lvl);
    chk("R6 period accepted while stopped", p_len, 21);
    chk("R6 duty unchanged", a_len, 4);

    // R7: duty rewrite while running
    wr(2'd2, 8'd12);
    measure(1'b0, a_len, p_len, i_aft, lvl);
    chk("R7 new duty active length", a_len, 13);

    // R8: output disabled, idle high
    wr(2'd0, ctrl_byte(1'b0, 3'd0, 2'b10, 1'b1, 1'b0));
    wr(2'd1, 8'd6);
    wr(2'd2, 8'd2);
    wr(2'd0, ctrl_byte(1'b1, 3'd0, 2'b10, 1'b1, 1'b0));
    wait_irq(100, c);
    chk("R8 irq continues with output off", int'(c > 0), 1);
    bad = 0;
    for (int i = 0; i < 14; i++) begin
      if (pwm != 1'b1) bad++;
      @(negedge clk);
    end
    chk("R8 pin holds idle when disabled", bad, 0);

    // R9: stop during active phase
    wr(2'd0, ctrl_byte(1'b0, 3'd0, 2'b10, 1'b0, 1'b1));
    wr(2'd1, 8'd20);
    wr(2'd2, 8'd15);
    wr(2'd0, ctrl_byte(1'b1, 3'd0, 2'b10, 1'b0, 1'b1));
    wait_irq(100, c);
    wr(2'd0, ctrl_byte(1'b0, 3'd0, 2'b10, 1'b0, 1'b1));
    @(negedge clk);
    chk("R9 output inactive after stop", int'(pwm), 0);
    wait_irq(40, c);
    chk("R9 no irq while stopped", c, -1);
    wr(2'd0, ctrl_byte(1'b1, 3'd0, 2'b10, 1'b0, 1'b1));
    wait_irq(100, c);
    chk("R9 restart first irq cycle", c, 21);

    // R10: non-PWM mode holds the counter
    wr(2'd0, ctrl_byte(1'b0, 3'd0, 2'b10, 1'b0, 1'b1));
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd1);
    wr(2'd0, ctrl_byte(1'b1, 3'd0, 2'b01, 1'b0, 1'b1));
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (irq) bad++;
    end
    chk("R10 no irq outside PWM mode", bad, 0);
    chk("R10 pin idle outside PWM mode", int'(pwm), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule